// File: doc/BRIEF.md
# Modulation-Scaled Unipolar PWM Comparator

This block sits between a waveform source and the gate drivers of a single-phase full bridge. Each cycle in which `sample_valid` is high, it takes three 8-bit samples: two offset-binary reference sines that are 180 degrees apart and one triangular carrier sample. It also reads a 16-bit modulation index. The index is turned into an 8-bit gain code that is itself offset by mid-scale. Each reference is scaled about mid-scale (code 128) by that gain, and each scaled reference is compared against the shared carrier. The two references switch the two bridge legs, which gives unipolar switching.

The outputs are four gate signals, a complementary pair for each leg. The scaling runs over two registers, and the carrier is delayed in step with it, so every comparison uses a reference and a carrier that were sampled together. Dead time and fault handling belong to the driver stage that follows.

Top module: `pwm_uni_mod`

## Requirements
- R1: The 16-bit index `m` maps to a gain code `code = 128 + floor((m*127 + 32767) / 65535)`. Index 0 gives 128 and index 65535 gives 255.
- R2: Each scaled reference is `128 + q`, clamped to 0..255, where `q = (y-128)*(code-128)/127` rounded to nearest with ties away from zero. A code of 128 gives a flat 128, and a code of 255 reproduces `y` unchanged.
- R3: The positive gate of a leg is 1 when that leg's scaled reference is greater than or equal to the carrier sample taken with it, and 0 otherwise. Equality gives 1.
- R4: The negative gate of each leg is the inverse of that leg's positive gate. Bit 0 of each gate vector is leg A and bit 1 is leg B.
- R5: Leg A is driven from `ref_a` and leg B from `ref_b`. Both legs compare against the same carrier sample.
- R6: A sample presented with `sample_valid` high at clock edge k appears on the gates after edge k+1, and not after edge k.
- R7: In a cycle where the sample stage held no valid sample, the gate outputs keep their previous values whatever the inputs do.
- R8: After reset, `gate_pos` is 2'b00 and `gate_neg` is 2'b11 until the first valid sample reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_index | input | 16 | Unsigned modulation index; 65535 means 1.0 |
| sample_valid | input | 1 | The reference and carrier samples are valid this cycle |
| ref_a | input | 8 | Constant-amplitude reference for leg A, offset binary |
| ref_b | input | 8 | Reference for leg B, shifted 180 degrees |
| carrier | input | 8 | Triangular carrier sample |
| gate_pos | output | 2 | Upper-switch gates: bit 0 leg A, bit 1 leg B |
| gate_neg | output | 2 | Lower-switch gates, complement of gate_pos |

## Verification
The bench sweeps 64 index values, from zero through full scale, against all 256 reference levels, with leg B the mirror of leg A. The carrier is placed exactly at the expected scaled level and then one code above it. A wrong rounding direction or an off-by-one in the code mapping therefore flips a gate, and so does a strict comparison where greater-or-equal is required.

Single-sample runs after reset target the two-edge latency and the idle state. A carrier that is misaligned by one register, or a gate that leaves idle early, shows up as an early or late pattern. A final stretch with no valid samples and changing inputs targets a pipeline that captures when it should hold.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    localparam int IDX_W    = 16;
    localparam int DW       = 8;
    localparam int NLEG     = 2;
    localparam int MID      = 1 << (DW - 1);
    localparam int GMAX     = MID - 1;
    localparam int TOP      = (1 << DW) - 1;
    localparam int IDX_FULL = (1 << IDX_W) - 1;
    localparam int PROD_W   = 2 * DW;

    typedef logic [DW-1:0]            samp_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // Index fraction to offset gain code, rounded to nearest.
    function automatic samp_t idx_to_code(input logic [IDX_W-1:0] m);
        logic [31:0] num;
        num = 32'(m) * 32'(GMAX) + 32'(IDX_FULL / 2);
        return samp_t'(32'(MID) + num / 32'(IDX_FULL));
    endfunction

    // Divide a signed product by the full gain, round ties away from zero,
    // re-centre on mid-scale and clamp into the sample range.
    function automatic samp_t scale_round(input prod_t p);
        int pi;
        int qi;
        pi = int'(p);
        if (pi < 0) qi = -((-pi + GMAX / 2) / GMAX);
        else        qi = (pi + GMAX / 2) / GMAX;
        qi = qi + MID;
        if (qi < 0)   qi = 0;
        if (qi > TOP) qi = TOP;
        return samp_t'(qi);
    endfunction
endpackage

// File: rtl/spwm_idx_coder.sv
module spwm_idx_coder
    import spwm_pkg::*;
(
    input  logic [IDX_W-1:0] mod_index,
    output samp_t            code
);
    assign code = idx_to_code(mod_index);
endmodule

// File: rtl/spwm_ref_scaler.sv
module spwm_ref_scaler
    import spwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_in,
    input  logic  en_s1,
    input  samp_t ref_in,
    input  samp_t code_in,
    output samp_t scaled
);
    logic signed [DW:0] dev;
    logic signed [DW:0] gain;
    prod_t              prod_d;
    prod_t              prod1;
    samp_t              code1;
    samp_t              ref1;

    assign dev    = $signed({1'b0, ref_in})  - $signed({1'b0, samp_t'(MID)});
    assign gain   = $signed({1'b0, code_in}) - $signed({1'b0, samp_t'(MID)});
    assign prod_d = prod_t'(dev) * prod_t'(gain);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod1 <= '0;
            code1 <= samp_t'(MID);
            ref1  <= samp_t'(MID);
        end else if (en_in) begin
            prod1 <= prod_d;
            code1 <= code_in;
            ref1  <= ref_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        scaled <= samp_t'(MID);
        else if (en_s1) scaled <= scale_round(prod1);
    end

    // R2: zero gain flattens the reference to mid-scale
    a_r2_zero_gain: assert property (@(posedge clk) disable iff (rst)
        (en_s1 && code1 == samp_t'(MID)) |=> (scaled == samp_t'(MID)));

    // R2: full gain passes the reference through unchanged
    a_r2_unity_gain: assert property (@(posedge clk) disable iff (rst)
        (en_s1 && code1 == samp_t'(TOP)) |=> (scaled == $past(ref1)));
endmodule

// File: rtl/spwm_leg_cmp.sv
module spwm_leg_cmp
    import spwm_pkg::*;
(
    input  logic  live,
    input  samp_t level,
    input  samp_t car,
    output logic  pos,
    output logic  neg
);
    assign pos = live & (level >= car);
    assign neg = ~pos;
endmodule

// File: rtl/pwm_uni_mod.sv
module pwm_uni_mod
    import spwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] mod_index,
    input  logic             sample_valid,
    input  logic [DW-1:0]    ref_a,
    input  logic [DW-1:0]    ref_b,
    input  logic [DW-1:0]    carrier,
    output logic [NLEG-1:0]  gate_pos,
    output logic [NLEG-1:0]  gate_neg
);
    samp_t code_w;
    samp_t refs   [NLEG];
    samp_t scaled [NLEG];
    samp_t car1;
    samp_t car2;
    logic  v1;
    logic  live;

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;

    spwm_idx_coder u_code (
        .mod_index (mod_index),
        .code      (code_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            live <= 1'b0;
            car1 <= '0;
            car2 <= '0;
        end else begin
            v1 <= sample_valid;
            if (sample_valid) car1 <= carrier;
            if (v1) begin
                car2 <= car1;
                live <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        spwm_ref_scaler u_scale (
            .clk     (clk),
            .rst     (rst),
            .en_in   (sample_valid),
            .en_s1   (v1),
            .ref_in  (refs[g]),
            .code_in (code_w),
            .scaled  (scaled[g])
        );
        spwm_leg_cmp u_cmp (
            .live  (live),
            .level (scaled[g]),
            .car   (car2),
            .pos   (gate_pos[g]),
            .neg   (gate_neg[g])
        );
    end

    // R1: the gain code never falls below mid-scale
    a_r1_code_floor: assert property (@(posedge clk) disable iff (rst)
        code_w >= samp_t'(MID));

    // R8: gates stay idle until a sample reaches the output
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !live |-> (gate_pos == '0 && gate_neg == '1));

    // R7: with no sample in the first stage the outputs hold
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(v1) |-> ($stable(gate_pos) && $stable(gate_neg)));
endmodule

// File: tb/sim_pwm_uni_mod.sv
module sim_pwm_uni_mod;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] m;
    logic        vld;
    logic [7:0]  ra, rb, car;
    logic [1:0]  gp, gn;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [1:0]  hist0, hist1;

    always #5 clk = ~clk;

    pwm_uni_mod u0 (
        .clk          (clk),
        .rst          (rst),
        .mod_index    (m),
        .sample_valid (vld),
        .ref_a        (ra),
        .ref_b        (rb),
        .carrier      (car),
        .gate_pos     (gp),
        .gate_neg     (gn)
    );

    function automatic int exp_code(int mi);
        return 128 + (mi * 127 + 32767) / 65535;
    endfunction

    function automatic int exp_ref(int y, int code);
        int p;
        int q;
        p = (y - 128) * (code - 128);
        if (p < 0) q = -((-p + 63) / 127);
        else       q = (p + 63) / 127;
        q = q + 128;
        if (q < 0)   q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Called just after a falling edge: check the sample from two steps ago,
    // then drive the next inputs and advance one cycle.
    task automatic step(bit v, int mi, int a, int b, int c, string tag);
        int code;
        chk({tag, " R3 gate_pos"}, gp, hist1);
        chk({tag, " R4 gate_neg"}, gn, ~hist1);
        hist1 = hist0;
        if (v) begin
            code  = exp_code(mi);
            hist0 = {1'(exp_ref(b, code) >= c), 1'(exp_ref(a, code) >= c)};
        end
        vld = v;
        m   = 16'(mi);
        ra  = 8'(a);
        rb  = 8'(b);
        car = 8'(c);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; vld = 1'b0; m = '0; ra = '0; rb = '0; car = '0;
        hist0 = 2'b00; hist1 = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset gate_pos", gp, 2'b00);
        chk("R8 reset gate_neg", gn, 2'b11);
        step(0, 65535, 255, 255, 0, "R8 idle");
        step(0, 1234, 200, 9, 3, "R8 idle");
        // R6: one sample, then watch the two edges that follow
        step(1, 65535, 200, 55, 100, "R6 latency");
        step(0, 0, 0, 0, 255, "R6 latency");
        step(0, 0, 0, 0, 255, "R6 latency");
        // R2: zero gain gives a flat mid-scale level
        step(1, 0, 255, 0, 128, "R2 zero gain");
        step(1, 0, 10, 250, 129, "R2 zero gain");
        step(1, 65535, 77, 178, 77, "R2 unity");
        step(1, 65535, 77, 178, 78, "R2 unity");
        // R1/R2/R3/R5 sweep: carrier at the expected level and one above it
        for (int i = 0; i < 64; i++) begin
            for (int y = 0; y < 256; y++) begin
                for (int k = 0; k < 2; k++) begin
                    int mi;
                    int ea;
                    int c;
                    mi = (i == 63) ? 65535 : i * 1040;
                    ea = exp_ref(y, exp_code(mi));
                    c  = (k == 0) ? ea : ((ea < 255) ? ea + 1 : ea);
                    step(1, mi, y, 255 - y, c, "R1 R2 R5 sweep");
                end
            end
        end
        // R7: no valid samples, changing inputs, outputs must hold
        for (int j = 0; j < 8; j++)
            step(0, j * 8000, (j * 37) & 255, (j * 91) & 255, (j * 53) & 255, "R7 hold");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule